// File: doc/BRIEF.md
# Chained Lookup-Table Refill Engine

This block loads page addresses into one of several two-dimensional lookup tables by walking a linked list of descriptors held in memory. Software hands it the address of the first descriptor. Each descriptor names a rectangle of table slots, a control word and two pointers: one to the entries for that rectangle and one to the next descriptor. The engine reads each descriptor, checks it, reads one 32-bit entry per slot and writes the entries into the selected table. It fills each row from left to right, then moves to the next row down.

A descriptor is five consecutive 32-bit words:

| Word | Contents |
|------|----------|
| 0 | {y0, x0} |
| 1 | {y1, x1} |
| 2 | control |
| 3 | entry pointer |
| 4 | next-descriptor pointer |

Each coordinate is 16 bits. In the control word, bit 0 enables filling and bits [9:8] select the table.

A next pointer of zero ends the chain. When the last descriptor finishes, the engine raises a one-cycle interrupt and returns to ready. Errors are sticky and leave the engine ready; they come from a misaligned pointer or a rectangle that does not fit the table. Writing a zero pointer cancels any work in progress. The table size comes from a geometry word on an input port.

Top module: `tbl_refill_engine`

## Requirements
- R1: While ready, a command with a nonzero pointer whose bits [3:0] are zero clears error, drops ready and reads the five descriptor words at pointer, pointer+4, ..., pointer+16.
- R2: A nonzero command pointer with any of bits [3:0] set sets error, leaves ready high, and causes no memory read and no table write.
- R3: The table width is geom_i[19:16]*32 and the table height is geom_i[27:24]*32. A rectangle is accepted only if x1 < width and y1 < height.
- R4: An accepted descriptor with control bit 0 set writes (x1-x0+1)*(y1-y0+1) entries. The entries are read from consecutive words starting at the entry pointer. They are written in row-major order (x changes fastest) with tw_id equal to control bits [9:8].
- R5: A descriptor with control bit 0 clear writes nothing, and the chain continues to its next pointer.
- R6: A descriptor with x1<x0, y1<y0, a rectangle outside the table, or an entry or next pointer with bits [3:0] nonzero sets error, stops the chain, returns to ready and writes nothing for that descriptor.
- R7: A nonzero next pointer continues the chain. A zero next pointer, once that descriptor's entries are written, pulses irq for exactly one cycle as ready returns.
- R8: A command with pointer zero puts the engine in ready on the next cycle, clears error, drops rd_req and suppresses any further table writes.
- R9: A nonzero command received while the engine is busy is ignored.
- R10: rd_req stays high with rd_addr unchanged until rd_ack. rd_data is taken in the rd_ack cycle, and the resulting table write appears on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle strobe for a command pointer |
| cmd_ptr | input | 32 | First descriptor address, or zero to abort |
| geom_i | input | 32 | Geometry word holding the width and height fields |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read byte address |
| rd_ack | input | 1 | Read accepted; rd_data is valid this cycle |
| rd_data | input | 32 | Memory read data |
| tw_en | output | 1 | Table write strobe |
| tw_id | output | 2 | Table selected by the write |
| tw_x | output | 16 | Column of the slot written |
| tw_y | output | 16 | Row of the slot written |
| tw_data | output | 32 | Entry written |
| ready | output | 1 | Engine idle |
| error | output | 1 | Sticky fault flag |
| irq | output | 1 | One-cycle pulse when the last descriptor completes |

## Verification
The hardest state to reach from the ports is an abort landing in the middle of a rectangle fill, while a read is outstanding and table writes are still in flight. The bench reaches it with a 32-slot descriptor. Memory acknowledges with an irregular stall pattern, and the bench waits until three writes have been seen before issuing a zero pointer. After the abort it discards the scoreboard's remaining expectations, so any later table write has nothing to match and is reported. The bench also builds a chain whose good first descriptor is followed by a malformed one. This shows that writes stop exactly at the descriptor boundary and that no interrupt is raised.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_FILL,
        ST_NEXT
    } rfe_state_e;

    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_TID_LSB = 8;
    localparam int GEO_W_LSB    = 16;
    localparam int GEO_H_LSB    = 24;
    localparam int GEO_FIELD_W  = 4;
    localparam int GEO_SCALE_SH = 5;
    localparam int DESC_WORDS   = 5;
endpackage

// File: rtl/rfe_walk.sv
module rfe_walk #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [CW-1:0] x0,
    input  logic [CW-1:0] y0,
    input  logic [CW-1:0] x1,
    input  logic [CW-1:0] y1,
    output logic [CW-1:0] cur_x,
    output logic [CW-1:0] cur_y,
    output logic          at_end
);
    typedef struct packed {
        logic [CW-1:0] x;
        logic [CW-1:0] y;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (load) begin
            pos_d.x = x0;
            pos_d.y = y0;
        end else if (step) begin
            if (pos_q.x == x1) begin
                pos_d.x = x0;
                pos_d.y = pos_q.y + CW'(1);
            end else begin
                pos_d.x = pos_q.x + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign cur_x  = pos_q.x;
    assign cur_y  = pos_q.y;
    assign at_end = (pos_q.x == x1) && (pos_q.y == y1);
endmodule

// File: rtl/rfe_desc_check.sv
module rfe_desc_check #(
    parameter int CW = 16
) (
    input  logic [2*CW-1:0] corner_lo,
    input  logic [2*CW-1:0] corner_hi,
    input  logic [2*CW-1:0] data_ptr,
    input  logic [2*CW-1:0] next_ptr,
    input  logic [2*CW-1:0] geom,
    output logic            bad
);
    import rfe_pkg::*;
    localparam int LIM_W = GEO_FIELD_W + GEO_SCALE_SH;

    logic [CW-1:0] x0, y0, x1, y1, lim_w, lim_h;
    logic          order_bad, bound_bad, align_bad;

    always_comb begin
        x0    = corner_lo[CW-1:0];
        y0    = corner_lo[2*CW-1:CW];
        x1    = corner_hi[CW-1:0];
        y1    = corner_hi[2*CW-1:CW];
        lim_w = CW'({geom[GEO_W_LSB +: GEO_FIELD_W], GEO_SCALE_SH'(0)});
        lim_h = CW'({geom[GEO_H_LSB +: GEO_FIELD_W], GEO_SCALE_SH'(0)});
        order_bad = (x1 < x0) || (y1 < y0);
        bound_bad = (x1 >= lim_w) || (y1 >= lim_h);
        align_bad = (data_ptr[3:0] != 4'd0) || (next_ptr[3:0] != 4'd0);
        bad = order_bad || bound_bad || align_bad;
    end

    logic unused_lim;
    assign unused_lim = ^LIM_W;
endmodule

// File: rtl/tbl_refill_engine.sv
module tbl_refill_engine #(
    parameter int CW    = 16,
    parameter int TID_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2*CW-1:0]   cmd_ptr,
    input  logic [2*CW-1:0]   geom_i,
    output logic              rd_req,
    output logic [2*CW-1:0]   rd_addr,
    input  logic              rd_ack,
    input  logic [2*CW-1:0]   rd_data,
    output logic              tw_en,
    output logic [TID_W-1:0]  tw_id,
    output logic [CW-1:0]     tw_x,
    output logic [CW-1:0]     tw_y,
    output logic [2*CW-1:0]   tw_data,
    output logic              ready,
    output logic              error,
    output logic              irq
);
    import rfe_pkg::*;
    localparam int WW = 2 * CW;
    localparam int IW = $clog2(DESC_WORDS);

    typedef struct packed {
        rfe_state_e       state;
        logic [WW-1:0]    ptr;
        logic [IW-1:0]    widx;
        logic [WW-1:0]    corner_lo;
        logic [WW-1:0]    corner_hi;
        logic [WW-1:0]    ctrl;
        logic [WW-1:0]    dptr;
        logic [WW-1:0]    nptr;
        logic             err;
        logic             irq;
        logic             wen;
        logic [TID_W-1:0] wid;
        logic [CW-1:0]    wx;
        logic [CW-1:0]    wy;
        logic [WW-1:0]    wdata;
    } eng_t;

    eng_t e_d, e_q;
    logic walk_load, walk_step, walk_end, desc_bad;
    logic [CW-1:0] cur_x, cur_y;

    rfe_walk #(.CW(CW)) u_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (walk_load),
        .step   (walk_step),
        .x0     (e_q.corner_lo[CW-1:0]),
        .y0     (e_q.corner_lo[WW-1:CW]),
        .x1     (e_q.corner_hi[CW-1:0]),
        .y1     (e_q.corner_hi[WW-1:CW]),
        .cur_x  (cur_x),
        .cur_y  (cur_y),
        .at_end (walk_end)
    );

    rfe_desc_check #(.CW(CW)) u_check (
        .corner_lo (e_q.corner_lo),
        .corner_hi (e_q.corner_hi),
        .data_ptr  (e_q.dptr),
        .next_ptr  (e_q.nptr),
        .geom      (geom_i),
        .bad       (desc_bad)
    );

    always_comb begin
        e_d       = e_q;
        e_d.irq   = 1'b0;
        e_d.wen   = 1'b0;
        walk_load = 1'b0;
        walk_step = 1'b0;
        unique case (e_q.state)
            ST_IDLE: begin
                if (cmd_valid && cmd_ptr != '0) begin
                    if (cmd_ptr[3:0] != 4'd0) begin
                        e_d.err = 1'b1;
                    end else begin
                        e_d.err   = 1'b0;
                        e_d.ptr   = cmd_ptr;
                        e_d.widx  = '0;
                        e_d.state = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (rd_ack) begin
                    case (e_q.widx)
                        IW'(0):  e_d.corner_lo = rd_data;
                        IW'(1):  e_d.corner_hi = rd_data;
                        IW'(2):  e_d.ctrl      = rd_data;
                        IW'(3):  e_d.dptr      = rd_data;
                        default: e_d.nptr      = rd_data;
                    endcase
                    e_d.ptr = e_q.ptr + WW'(4);
                    if (e_q.widx == IW'(DESC_WORDS - 1)) e_d.state = ST_CHECK;
                    else                                 e_d.widx  = e_q.widx + IW'(1);
                end
            end
            ST_CHECK: begin
                if (desc_bad) begin
                    e_d.err   = 1'b1;
                    e_d.state = ST_IDLE;
                end else if (e_q.ctrl[CTRL_GO_BIT]) begin
                    walk_load = 1'b1;
                    e_d.ptr   = e_q.dptr;
                    e_d.state = ST_FILL;
                end else begin
                    e_d.state = ST_NEXT;
                end
            end
            ST_FILL: begin
                if (rd_ack) begin
                    e_d.wen   = 1'b1;
                    e_d.wid   = e_q.ctrl[CTRL_TID_LSB +: TID_W];
                    e_d.wx    = cur_x;
                    e_d.wy    = cur_y;
                    e_d.wdata = rd_data;
                    e_d.ptr   = e_q.ptr + WW'(4);
                    if (walk_end) e_d.state = ST_NEXT;
                    else          walk_step = 1'b1;
                end
            end
            ST_NEXT: begin
                if (e_q.nptr == '0) begin
                    e_d.irq   = 1'b1;
                    e_d.state = ST_IDLE;
                end else begin
                    e_d.ptr   = e_q.nptr;
                    e_d.widx  = '0;
                    e_d.state = ST_FETCH;
                end
            end
            default: e_d.state = ST_IDLE;
        endcase
        if (cmd_valid && cmd_ptr == '0) begin
            e_d.state = ST_IDLE;
            e_d.err   = 1'b0;
            e_d.irq   = 1'b0;
            e_d.wen   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q       <= '0;
            e_q.state <= ST_IDLE;
        end else begin
            e_q <= e_d;
        end
    end

    assign rd_req  = (e_q.state == ST_FETCH) || (e_q.state == ST_FILL);
    assign rd_addr = e_q.ptr;
    assign tw_en   = e_q.wen;
    assign tw_id   = e_q.wid;
    assign tw_x    = e_q.wx;
    assign tw_y    = e_q.wy;
    assign tw_data = e_q.wdata;
    assign ready   = (e_q.state == ST_IDLE);
    assign error   = e_q.err;
    assign irq     = e_q.irq;
endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
    parameter int CW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [2*CW-1:0] cmd_ptr,
    input logic [2*CW-1:0] geom_i,
    input logic            rd_req,
    input logic [2*CW-1:0] rd_addr,
    input logic            rd_ack,
    input logic            tw_en,
    input logic [CW-1:0]   tw_x,
    input logic [CW-1:0]   tw_y,
    input logic            ready,
    input logic            error,
    input logic            irq
);
    logic [CW-1:0] lim_w, lim_h;
    assign lim_w = CW'({geom_i[19:16], 5'b0});
    assign lim_h = CW'({geom_i[27:24], 5'b0});

    p_rd_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[1:0] == 2'b00));

    p_ready_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !rd_req);

    p_in_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tw_en |-> (tw_x < lim_w && tw_y < lim_h));

    p_err_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> ready);

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ptr == '0) |=> (ready && !error && !rd_req && !tw_en));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && !(cmd_valid && cmd_ptr == '0)) |=> (rd_req && $stable(rd_addr)));
endmodule

bind tbl_refill_engine rfe_checker #(.CW(CW)) u_rfe_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ptr   (cmd_ptr),
    .geom_i    (geom_i),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ack    (rd_ack),
    .tw_en     (tw_en),
    .tw_x      (tw_x),
    .tw_y      (tw_y),
    .ready     (ready),
    .error     (error),
    .irq       (irq)
);

// File: tb/sim_tbl_refill_engine.sv
`timescale 1ns/1ps
module sim_tbl_refill_engine;
    typedef struct packed {
        logic [1:0]  id;
        logic [15:0] x;
        logic [15:0] y;
        logic [31:0] d;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_ptr = '0;
    logic [31:0] geom_i = 32'h0100_0000 | 32'h0001_0000;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic        tw_en;
    logic [1:0]  tw_id;
    logic [15:0] tw_x, tw_y;
    logic [31:0] tw_data;
    logic        ready, error, irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int wr_cnt = 0;
    int xfer_cnt = 0;
    int stall = 0;
    logic [31:0] mem [0:1023];
    exp_t q[$];

    always #4 clk = ~clk;

    tbl_refill_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ptr(cmd_ptr),
        .geom_i(geom_i), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data), .tw_en(tw_en), .tw_id(tw_id), .tw_x(tw_x),
        .tw_y(tw_y), .tw_data(tw_data), .ready(ready), .error(error), .irq(irq)
    );

    // memory responder with irregular stalls
    always @(posedge clk) begin
        stall <= stall + 1;
        rd_ack  <= rd_req && !rd_ack && ((stall % 5) != 3);
        rd_data <= mem[rd_addr[11:2]];
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // monitor: pops the scoreboard on each table write (R4, R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_req && rd_ack) xfer_cnt++;
            if (irq) irq_cnt++;
            if (tw_en) begin
                wr_cnt++;
                if (q.size() == 0) begin
                    chk(1'b0, "R4 unexpected table write", {tw_id, tw_x, tw_y}, 64'h0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk({tw_id, tw_x, tw_y, tw_data} == e, "R4 write content/order",
                        {tw_x, tw_y, tw_data}, {e.x, e.y, e.d});
                end
            end
        end
    end

    task automatic put_desc(input int a, input int x0, input int y0, input int x1, input int y1,
                            input logic [31:0] ctrl, input logic [31:0] dp, input logic [31:0] np,
                            input bit good);
        mem[a/4 + 0] = {16'(y0), 16'(x0)};
        mem[a/4 + 1] = {16'(y1), 16'(x1)};
        mem[a/4 + 2] = ctrl;
        mem[a/4 + 3] = dp;
        mem[a/4 + 4] = np;
        if (good && ctrl[0]) begin
            int k = 0;
            for (int y = y0; y <= y1; y++) begin
                for (int x = x0; x <= x1; x++) begin
                    logic [31:0] v;
                    v = 32'hD000_0000 ^ (dp + 32'(4 * k)) ^ 32'(a << 12);
                    mem[dp/4 + k] = v;
                    q.push_back({ctrl[9:8], 16'(x), 16'(y), v});
                    k++;
                end
            end
        end
    endtask

    task automatic send(input logic [31:0] p);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_ptr   = p;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_ptr   = '0;
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!ready && n < 4000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int irq0, x0c, w0c;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && !error && !irq && !tw_en && !rd_req, "R1 reset state",
            {ready, error, irq, tw_en, rd_req}, 64'b10000);

        // chain of four: two fills, a skipped one, a single slot corner
        put_desc(32'h100, 2, 3, 4, 4, 32'h101, 32'h400, 32'h120, 1'b1);
        put_desc(32'h120, 0, 0, 0, 2, 32'h201, 32'h500, 32'h140, 1'b1);
        put_desc(32'h140, 0, 0, 1, 1, 32'h300, 32'h600, 32'h160, 1'b1); // R5 no fill
        put_desc(32'h160, 31, 31, 31, 31, 32'h001, 32'h700, 32'h0, 1'b1);
        irq0 = irq_cnt;
        send(32'h100);
        chk(!ready, "R1 busy after start", ready, 0);
        wait_ready();
        chk(q.size() == 0, "R4 all entries written", q.size(), 0);
        chk(wr_cnt == 10, "R5 skipped descriptor wrote nothing", wr_cnt, 10);
        chk(irq_cnt == irq0 + 1, "R7 one irq at chain end", irq_cnt - irq0, 1);
        chk(!error, "R1 no error", error, 0);

        // misaligned command pointer
        x0c = xfer_cnt; w0c = wr_cnt;
        send(32'h108);
        chk(ready && error, "R2 misaligned cmd sets error", {ready, error}, 2'b11);
        repeat (5) @(negedge clk);
        chk(xfer_cnt == x0c && wr_cnt == w0c, "R2 no reads or writes", xfer_cnt - x0c, 0);

        // good descriptor then reversed rectangle
        put_desc(32'h220, 1, 1, 1, 1, 32'h301, 32'h800, 32'h200, 1'b1);
        put_desc(32'h200, 5, 0, 4, 0, 32'h001, 32'h840, 32'h0, 1'b0);
        irq0 = irq_cnt;
        send(32'h220);
        wait_ready();
        chk(error && ready, "R6 reversed x sets error", {error, ready}, 2'b11);
        chk(q.size() == 0, "R6 first descriptor still written", q.size(), 0);
        chk(irq_cnt == irq0, "R6 no irq on faulted chain", irq_cnt - irq0, 0);

        // row past height 32 fails, then passes when height is 64
        put_desc(32'h240, 0, 31, 0, 32, 32'h001, 32'h880, 32'h0, 1'b0);
        w0c = wr_cnt;
        send(32'h240);
        wait_ready();
        chk(error && wr_cnt == w0c, "R3 y1 beyond height rejected", wr_cnt - w0c, 0);
        geom_i = 32'h0200_0000 | 32'h0001_0000;
        put_desc(32'h240, 0, 31, 0, 32, 32'h101, 32'h880, 32'h0, 1'b1);
        irq0 = irq_cnt;
        send(32'h240);
        wait_ready();
        chk(!error && q.size() == 0 && irq_cnt == irq0 + 1, "R3 larger height accepted",
            {error, 8'(q.size())}, 0);
        geom_i = 32'h0100_0000 | 32'h0001_0000;

        // misaligned data pointer, misaligned next pointer
        put_desc(32'h260, 0, 0, 1, 0, 32'h001, 32'h804, 32'h0, 1'b0);
        w0c = wr_cnt;
        send(32'h260);
        wait_ready();
        chk(error && wr_cnt == w0c, "R6 misaligned entry pointer", wr_cnt - w0c, 0);
        put_desc(32'h280, 0, 0, 1, 0, 32'h001, 32'h8C0, 32'h2A8, 1'b0);
        send(32'h280);
        wait_ready();
        chk(error && wr_cnt == w0c, "R6 misaligned next pointer", wr_cnt - w0c, 0);

        // abort in the middle of a 32-slot fill
        put_desc(32'h2C0, 0, 0, 7, 3, 32'h201, 32'h900, 32'h0, 1'b1);
        w0c = wr_cnt; irq0 = irq_cnt;
        send(32'h2C0);
        chk(!error, "R1 new start clears error", error, 0);
        while (wr_cnt < w0c + 3) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_ptr   = 32'h0;
        @(posedge clk);
        #1;
        q.delete();
        cmd_valid = 1'b0;
        chk(ready && !error && !rd_req, "R8 abort returns to ready", {ready, error, rd_req}, 3'b100);
        w0c = wr_cnt;
        repeat (40) @(negedge clk);
        chk(wr_cnt == w0c, "R8 no writes after abort", wr_cnt - w0c, 0);
        chk(irq_cnt == irq0, "R8 no irq after abort", irq_cnt - irq0, 0);

        // nonzero command while busy is ignored
        put_desc(32'h2E0, 0, 0, 3, 0, 32'h101, 32'hA00, 32'h0, 1'b1);
        irq0 = irq_cnt; w0c = wr_cnt;
        send(32'h2E0);
        send(32'h100);
        wait_ready();
        chk(wr_cnt == w0c + 4, "R9 busy command ignored", wr_cnt - w0c, 4);
        chk(irq_cnt == irq0 + 1 && q.size() == 0, "R7 single irq", irq_cnt - irq0, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule